// File: doc/BRIEF.md
# I2C EEPROM Write Target

This block is the write side of a small serial EEPROM that sits on an I2C bus. A fast system clock samples SCL and SDA. The block finds START and STOP conditions and decodes a select byte and an address byte. It then gathers either one data byte or a run of data bytes into a 16-entry page latch. The array is a plain register memory. The upper address bits come from the select byte, and the low eight bits come from the address byte. The block acknowledges by pulling an open-drain style output enable high, which drives SDA low.

Data reaches the array only when the master ends the transfer with a STOP placed right after an acknowledged data byte. That STOP starts an internal program cycle with a fixed length. For the whole cycle the block ignores the bus and answers nothing. A master can poll the select byte until it gets an ACK to learn that the cycle has ended. When the write-control input is high, data bytes are refused and the array is left alone. A side read port exposes the array contents to the read path, which lives outside this block.

Top module: `i2cw_top`

## Requirements
- R1: After reset, sdaOe is 0, busy is 0 and every array byte reads 0 on the peek port.
- R2: The select byte is ACKed only when its bits 7..4 equal 1010 and bit 0 (direction) is 0. Any other select byte gets NoACK, and the rest of that transfer changes nothing.
- R3: The address byte after an accepted select is always ACKed. Select bits ADDR_W-8..1 supply address bits ADDR_W-1..8.
- R4: A byte write is accepted when writeCtl is low and is followed by a STOP in the slot after the data ACK. busy then rises, and after the program cycle the addressed byte holds the data.
- R5: After each accepted data byte, only address bits 3..0 advance, wrapping inside the row. When more than 16 bytes are sent, later bytes overwrite earlier ones, and the last write to each location wins.
- R6: Only locations written in the transfer change. All other bytes of the row keep their old contents.
- R7: While writeCtl is high, every data byte gets NoACK. A STOP then starts no program cycle, and the array stays unchanged.
- R8: A STOP that comes anywhere other than the first bit slot after an ACKed data byte starts no program cycle, and the latched bytes are dropped.
- R9: A START in the middle of a transfer drops the latched bytes without programming.
- R10: busy stays high for exactly PROG_CYCLES clocks. While it is high the block ACKs nothing, not even a valid select byte. ACKs resume after busy falls.
- R11: The block asserts sdaOe only from the SCL fall after bit 8 of an ACKed byte, and releases it at the SCL fall after the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| writeCtl | input | 1 | High refuses all data bytes |
| sdaOe | output | 1 | High pulls SDA low (ACK) |
| busy | output | 1 | Program cycle in progress |
| peekAddr | input | ADDR_W | Array read address for the read path |
| peekData | output | 8 | Array byte at peekAddr |

## Verification
The delicate overlap is the SDA rising edge of a STOP and the bit counter of the byte that follows an ACK. The STOP is decoded in the same clock in which the counter shows one sampled bit, and the commit decision rests on that single comparison. The bench places STOPs in that first slot and again after four bits of a byte, and also after a NoACKed byte. It judges each case by whether busy rises for exactly the program length and by a sweep of the full array against an arithmetic model.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int MAX_AW = 11;
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_ADDR, ST_DATA, ST_SKIP
  } busState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic              clr;
    logic              loadAddr;
    logic              push;
    logic              commit;
    logic [MAX_AW-1:0] addr;
    logic [7:0]        data;
  } strobe_t;
endpackage

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic    writeCtl,
  input  logic    busy,
  output strobe_t strb,
  output logic    sdaOe
);
  logic [1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall, startCond, stopCond;
  busState_t state;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic [2:0] blkBits;
  logic ackOe, dataAcked;

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclRise   = sclS & ~sclP;
  assign sclFall   = ~sclS & sclP;
  assign startCond = sclS & sclP & sdaP & ~sdaS;
  assign stopCond  = sclS & sclP & ~sdaP & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shiftReg  <= '0;
      blkBits   <= '0;
      ackOe     <= 1'b0;
      dataAcked <= 1'b0;
      strb      <= '0;
    end else begin
      strb <= '0;
      if (busy) begin
        state     <= ST_IDLE;
        bitCnt    <= '0;
        ackOe     <= 1'b0;
        dataAcked <= 1'b0;
      end else if (startCond) begin
        state     <= ST_SEL;
        bitCnt    <= '0;
        ackOe     <= 1'b0;
        dataAcked <= 1'b0;
        strb.clr  <= 1'b1;
      end else if (stopCond) begin
        // commit only in the first bit slot after an acked data byte
        if (state == ST_DATA && bitCnt == 4'd1 && dataAcked)
          strb.commit <= 1'b1;
        else
          strb.clr <= 1'b1;
        state     <= ST_IDLE;
        bitCnt    <= '0;
        ackOe     <= 1'b0;
        dataAcked <= 1'b0;
      end else if (state == ST_SEL || state == ST_ADDR || state == ST_DATA) begin
        if (sclRise) begin
          if (bitCnt < 4'd8) shiftReg <= {shiftReg[6:0], sdaS};
          bitCnt <= bitCnt + 4'd1;
        end else if (sclFall && bitCnt == 4'd8) begin
          case (state)
            ST_SEL: begin
              if (shiftReg[7:4] == TYPE_CODE && !shiftReg[0]) begin
                ackOe   <= 1'b1;
                blkBits <= shiftReg[3:1];
                state   <= ST_ADDR;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_ADDR: begin
              ackOe         <= 1'b1;
              strb.loadAddr <= 1'b1;
              strb.addr     <= {blkBits, shiftReg};
              state         <= ST_DATA;
            end
            default: begin
              dataAcked <= !writeCtl;
              if (!writeCtl) begin
                ackOe     <= 1'b1;
                strb.push <= 1'b1;
                strb.data <= shiftReg;
              end
            end
          endcase
        end else if (sclFall && bitCnt == 4'd9) begin
          ackOe  <= 1'b0;
          bitCnt <= '0;
        end
      end
    end
  end

  assign sdaOe = ackOe;

  // R10
  noack_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ackOe);

  // R11
  ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOe) |-> !sclS);
endmodule

// File: rtl/i2cw_data.sv
module i2cw_data
  import i2cw_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PROG_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic              busy,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [7:0]        peekData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 16;
  localparam int ROW_W = ADDR_W - 4;
  localparam int TW    = $clog2(PROG_CYCLES + 1);

  logic [7:0]       latch [PAGE];
  logic [PAGE-1:0]  valid;
  logic [ROW_W-1:0] row;
  logic [3:0]       ptr;
  logic [TW-1:0]    timer;
  logic [7:0]       mem [DEPTH];
  logic             progDone;

  assign progDone = busy && (timer == TW'(PROG_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (strb.push && !busy) latch[ptr] <= strb.data;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid <= '0;
      row   <= '0;
      ptr   <= '0;
      busy  <= 1'b0;
      timer <= '0;
    end else if (busy) begin
      if (progDone) begin
        busy  <= 1'b0;
        valid <= '0;
        timer <= '0;
      end else begin
        timer <= timer + TW'(1);
      end
    end else if (strb.commit) begin
      busy  <= |valid;
      timer <= '0;
    end else if (strb.clr) begin
      valid <= '0;
    end else if (strb.loadAddr) begin
      row   <= strb.addr[ADDR_W-1:4];
      ptr   <= strb.addr[3:0];
      valid <= '0;
    end else if (strb.push) begin
      valid[ptr] <= 1'b1;
      ptr        <= ptr + 4'd1;   // low four bits only: wraps in the row
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (progDone) begin
      for (int i = 0; i < PAGE; i++)
        if (valid[i]) mem[{row, 4'(i)}] <= latch[i];
    end
  end

  assign peekData = mem[peekAddr];

  // R10
  push_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> !busy);

  // R4
  commit_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strb.commit));

  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (valid == '0));

  // R8
  clr_nobusy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clr && !busy) |=> !busy);
endmodule

// File: rtl/i2cw_top.sv
module i2cw_top
  import i2cw_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PROG_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              writeCtl,
  output logic              sdaOe,
  output logic              busy,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [7:0]        peekData
);
  strobe_t strb;

  i2cw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .writeCtl (writeCtl),
    .busy     (busy),
    .strb     (strb),
    .sdaOe    (sdaOe)
  );

  i2cw_data #(
    .ADDR_W      (ADDR_W),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busy     (busy),
    .peekAddr (peekAddr),
    .peekData (peekData)
  );
endmodule

// File: tb/tb_i2cw_top.sv
`timescale 1ns/1ps
module tb_i2cw_top;
  localparam int AW   = 9;
  localparam int PROG = 600;
  localparam int Q    = 10;
  localparam int NMEM = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, sclM, sdaM, wc;
  logic sdaOe, busy;
  logic [AW-1:0] peekAddr;
  logic [7:0] peekData;
  logic sdaLine;
  assign sdaLine = sdaM & ~sdaOe;

  i2cw_top #(.ADDR_W(AW), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .writeCtl(wc), .sdaOe(sdaOe), .busy(busy),
    .peekAddr(peekAddr), .peekData(peekData)
  );

  int errors = 0, checks = 0, busyCount = 0;
  bit done = 0;
  logic oeEarly, oeLate;
  logic [7:0] model [NMEM];

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dataOf(input int seed, input int i);
    return 8'((seed + i * 37) & 255);
  endfunction

  task automatic busStart();
    sdaM = 1; tick(Q); sclM = 1; tick(Q); sdaM = 0; tick(Q); sclM = 0; tick(Q);
  endtask

  task automatic busBit(input logic b);
    sdaM = b; tick(Q); sclM = 1; tick(2 * Q); sclM = 0; tick(Q);
  endtask

  task automatic busByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) busBit(b[i]);
    sdaM = 1; tick(Q);
    oeEarly = sdaOe;
    sclM = 1; tick(Q);
    ack = !sdaLine;
    tick(Q); sclM = 0; tick(Q);
    oeLate = sdaOe;
  endtask

  task automatic busStop();
    sdaM = 0; tick(Q); sclM = 1; tick(Q); sdaM = 1;
    busyCount = 0;
    for (int k = 0; k < 20; k++) begin
      tick(1);
      if (busy) busyCount++;
    end
  endtask

  task automatic waitIdle();
    while (busy) begin
      tick(1);
      if (busy) busyCount++;
    end
    tick(5);
  endtask

  task automatic writeXfer(input int addr, input int n, input logic wcV,
                           input int seed, output int acks);
    logic a;
    acks = 0;
    wc = wcV;
    busStart();
    busByte({4'b1010, 3'((addr >> 8) & 7), 1'b0}, a); acks += int'(a);
    busByte(8'(addr & 255), a); acks += int'(a);
    for (int i = 0; i < n; i++) begin
      busByte(dataOf(seed, i), a);
      acks += int'(a);
    end
    busStop();
    if (!wcV)
      for (int i = 0; i < n; i++)
        model[(addr & ~15) | ((addr + i) & 15)] = dataOf(seed, i);
    wc = 0;
  endtask

  task automatic compareAll(input string req);
    int mism = 0;
    for (int a = 0; a < NMEM; a++) begin
      peekAddr = AW'(a);
      tick(1);
      if (peekData !== model[a]) mism++;
    end
    chk(req, mism, 0, "array mismatches");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int acks;
    logic a;
    int polls;
    bit gotAck;
    for (int i = 0; i < NMEM; i++) model[i] = 8'h00;
    sclM = 1; sdaM = 1; wc = 0; rstN = 0; peekAddr = '0;
    tick(5); rstN = 1; tick(5);

    // R1 reset state
    chk("R1", int'(sdaOe), 0, "sdaOe after reset");
    chk("R1", int'(busy), 0, "busy after reset");
    compareAll("R1");

    // R4 / R3 byte write, upper bit from select byte
    writeXfer(9'h1F3, 1, 1'b0, 77, acks);
    chk("R4", acks, 3, "acks in byte write");
    chk("R11", int'(oeEarly), 1, "sdaOe before ninth clock");
    chk("R11", int'(oeLate), 0, "sdaOe after ninth clock");
    waitIdle();
    chk("R10", busyCount, PROG, "busy cycles");
    compareAll("R3");

    // R6 full row, then partial wrapping write in same row
    writeXfer(9'h020, 16, 1'b0, 5, acks);
    chk("R5", acks, 18, "acks full page");
    waitIdle();
    writeXfer(9'h02C, 5, 1'b0, 200, acks);
    chk("R5", acks, 7, "acks wrapping page");
    waitIdle();
    compareAll("R6");

    // R5 more than 16 bytes overwrite within the row
    writeXfer(9'h085, 20, 1'b0, 31, acks);
    waitIdle();
    chk("R5", busyCount, PROG, "busy cycles long page");
    compareAll("R5");

    // R7 write-control high
    writeXfer(9'h040, 3, 1'b1, 99, acks);
    chk("R7", acks, 2, "acks with writeCtl high");
    chk("R7", busyCount, 0, "busy with writeCtl high");
    waitIdle();
    compareAll("R7");

    // R8 STOP inside a byte
    busStart();
    busByte(8'hA0, a); busByte(8'h50, a);
    busByte(8'h11, a); busByte(8'h22, a);
    for (int i = 0; i < 4; i++) busBit(1'b0);
    busStop();
    chk("R8", busyCount, 0, "busy after misplaced stop");
    compareAll("R8");

    // R8 STOP right after the address byte
    busStart();
    busByte(8'hA0, a); busByte(8'h60, a);
    busStop();
    chk("R8", busyCount, 0, "busy after stop with no data");

    // R9 START aborts
    busStart();
    busByte(8'hA2, a); busByte(8'h10, a);
    busByte(8'h33, a); busByte(8'h44, a);
    busStart();
    busStop();
    chk("R9", busyCount, 0, "busy after restart");
    compareAll("R9");

    // R2 type-code sweep
    for (int t = 0; t < 16; t++) begin
      busStart();
      busByte({4'(t), 3'b000, 1'b0}, a);
      busStop();
      chk("R2", int'(a), (t == 10) ? 1 : 0, $sformatf("select ack type %0d", t));
    end
    busStart(); busByte(8'hA1, a); busStop();
    chk("R2", int'(a), 0, "read-direction select");
    busStart();
    busByte(8'hB0, a); busByte(8'h70, a); busByte(8'h5A, a);
    busStop();
    chk("R2", busyCount, 0, "busy after refused select");
    compareAll("R2");

    // R10 ACK polling during program cycle
    writeXfer(9'h100, 4, 1'b0, 150, acks);
    chk("R10", int'(busy), 1, "busy after page stop");
    polls = 0; gotAck = 0;
    for (int p = 0; p < 20 && !gotAck; p++) begin
      busStart(); busByte(8'hA2, a); busStop();
      if (a) gotAck = 1; else polls++;
    end
    chk("R10", int'(polls > 0), 1, "polls refused while busy");
    chk("R10", int'(gotAck), 1, "select acked after busy");
    waitIdle();
    compareAll("R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule